// File: doc/BRIEF.md
# TDC Reference Time Subtractor

This block sits behind the readout of a multichannel high-resolution TDC and removes the jitter that the common readout trigger adds to every event. The readout trigger is aligned to a slow clock, so it can be 25 ns away from the accept signal. The trigger logic clock adds up to 4 ns more against the pretrigger. To cancel this, one TDC channel receives a copy of the pretrigger and serves as the reference. Every other hit time in the event is taken relative to that reference hit.

The input is a stream of words. A start marker opens an event, hit words carry a channel number and a time in 100 ps units, and an end marker closes the event. The reference hit may appear anywhere inside the event, so the block stores the non-reference hits until the end marker arrives. It then replays the event as a start marker, the corrected hits in arrival order and an end marker. Each output word has an error bit that reports whether a reference hit was found. The reference channel number comes from a configuration input.

Top module: `tdc_ref_sub`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: After the end marker is accepted, the output carries a start marker (out_start=1), then the stored hits in arrival order, then an end marker (out_end=1). These words come on consecutive cycles with out_valid held high, and out_valid is low on the cycle after the end marker.
- R3: in_ready stays low from the cycle after the end marker is accepted until the output end marker has been sent. A word held on the input during that time is not taken.
- R4: When the event holds a reference hit, each output hit time equals the hit time minus the reference time. The result is a signed value one bit wider than the input time, and it is negative when the hit comes before the reference.
- R5: Hits on the reference channel are never emitted as output hit words.
- R6: When the reference channel has several hits in one event, the smallest time among them is the reference.
- R7: When an event has no reference hit, out_err is 1 on every output word of that event, markers included. Each hit time is passed through unchanged as a non-negative value.
- R8: When an event has a reference hit, out_err is 0 on every output word of that event.
- R9: An event keeps at most DEPTH non-reference hits. Later ones are dropped, and a reference hit that arrives after that point is still used.
- R10: Hit or end words presented while no event is open produce no output.
- R11: A start marker inside an open event discards everything collected so far and opens a new event.
- R12: The reference channel is the value of cfg_ref_chan sampled with the start marker. Later changes during the event have no effect on it.
- R13: An event with no hits is replayed as a start marker followed directly by an end marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ref_chan | input | CHAN_W | Channel number that carries the pretrigger copy |
| in_valid | input | 1 | Input word present |
| in_start | input | 1 | Input word is an event start marker (takes precedence over in_end) |
| in_end | input | 1 | Input word is an event end marker |
| in_chan | input | CHAN_W | Hit channel number |
| in_time | input | TIME_W | Hit time, unsigned, 100 ps units |
| in_ready | output | 1 | Block accepts an input word this cycle |
| out_valid | output | 1 | Output word present |
| out_start | output | 1 | Output word is the event start marker |
| out_end | output | 1 | Output word is the event end marker |
| out_chan | output | CHAN_W | Channel of the output hit (zero on markers) |
| out_time | output | TIME_W+1 | Signed corrected time (zero on markers) |
| out_err | output | 1 | No reference hit was found in this event |

## Verification
The checker watches the output framing on every cycle. It confirms that the stream stays gap-free from start marker to end marker and goes quiet after the end marker. It also confirms that input and output never overlap, that the error bit stays constant within one event, and that no event replays more than DEPTH hits. The numeric rules can only be shown by the bench's scenarios, which compare every word against a model built from the requirements. These rules are the subtraction, including negative results, the choice of the earliest reference hit, pass-through on a missing reference, restart on a repeated start marker and sampling of the configured channel.

// File: rtl/tdc_ref_pkg.sv
package tdc_ref_pkg;

    localparam int DEF_CHAN_W = 5;
    localparam int DEF_TIME_W = 19;
    localparam int DEF_DEPTH  = 16;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_COLLECT,
        ST_HEAD,
        ST_BODY,
        ST_TAIL
    } seq_state_e;

    // True when a (lower) candidate should replace the held reference time.
    function automatic logic earlier_ref(input logic found, input logic lower);
        return !found || lower;
    endfunction

endpackage

// File: rtl/tdc_hit_buffer.sv
module tdc_hit_buffer #(
    parameter int CHAN_W = 5,
    parameter int TIME_W = 19,
    parameter int DEPTH  = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [CHAN_W-1:0] wr_chan,
    input  logic [TIME_W-1:0] wr_time,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [CHAN_W-1:0] rd_chan,
    output logic [TIME_W-1:0] rd_time
);

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic [TIME_W-1:0] tval;
    } slot_t;

    slot_t store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_idx] <= '{chan: wr_chan, tval: wr_time};
        end
    end

    always_comb begin
        rd_chan = store[rd_idx].chan;
        rd_time = store[rd_idx].tval;
    end

endmodule

// File: rtl/tdc_ref_tracker.sv
module tdc_ref_tracker
    import tdc_ref_pkg::*;
#(
    parameter int CHAN_W = 5,
    parameter int TIME_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic [CHAN_W-1:0] sel_chan,
    input  logic              hit_en,
    input  logic [CHAN_W-1:0] hit_chan,
    input  logic [TIME_W-1:0] hit_time,
    output logic              is_ref,
    output logic              found,
    output logic [TIME_W-1:0] ref_time
);

    assign is_ref = (hit_chan == sel_chan);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            found    <= 1'b0;
            ref_time <= '0;
        end else if (hit_en && is_ref && earlier_ref(found, hit_time < ref_time)) begin
            found    <= 1'b1;
            ref_time <= hit_time;
        end
    end

endmodule

// File: rtl/tdc_ref_sub.sv
module tdc_ref_sub
    import tdc_ref_pkg::*;
#(
    parameter int CHAN_W = DEF_CHAN_W,
    parameter int TIME_W = DEF_TIME_W,
    parameter int DEPTH  = DEF_DEPTH,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int OUT_W = TIME_W + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [CHAN_W-1:0]       cfg_ref_chan,
    input  logic                    in_valid,
    input  logic                    in_start,
    input  logic                    in_end,
    input  logic [CHAN_W-1:0]       in_chan,
    input  logic [TIME_W-1:0]       in_time,
    output logic                    in_ready,
    output logic                    out_valid,
    output logic                    out_start,
    output logic                    out_end,
    output logic [CHAN_W-1:0]       out_chan,
    output logic signed [OUT_W-1:0] out_time,
    output logic                    out_err
);

    seq_state_e        state_q;
    logic [CNT_W-1:0]  fill_q;
    logic [IDX_W-1:0]  rd_q;
    logic [CHAN_W-1:0] sel_q;

    logic              take;
    logic              open_evt;
    logic              close_evt;
    logic              hit_take;
    logic              is_ref;
    logic              found;
    logic [TIME_W-1:0] ref_time;
    logic              wr_en;
    logic [CHAN_W-1:0] rd_chan;
    logic [TIME_W-1:0] rd_time;
    logic              last_rd;

    assign in_ready  = (state_q == ST_WAIT) || (state_q == ST_COLLECT);
    assign take      = in_valid && in_ready;
    assign open_evt  = take && in_start;
    assign close_evt = take && !in_start && in_end && (state_q == ST_COLLECT);
    assign hit_take  = take && !in_start && !in_end && (state_q == ST_COLLECT);
    assign wr_en     = hit_take && !is_ref && (fill_q < CNT_W'(DEPTH));
    assign last_rd   = (CNT_W'(rd_q) + CNT_W'(1)) == fill_q;

    tdc_ref_tracker #(.CHAN_W(CHAN_W), .TIME_W(TIME_W)) u_track (
        .clk      (clk),
        .rst      (rst),
        .clear    (open_evt),
        .sel_chan (sel_q),
        .hit_en   (hit_take),
        .hit_chan (in_chan),
        .hit_time (in_time),
        .is_ref   (is_ref),
        .found    (found),
        .ref_time (ref_time)
    );

    tdc_hit_buffer #(.CHAN_W(CHAN_W), .TIME_W(TIME_W), .DEPTH(DEPTH)) u_buf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (fill_q[IDX_W-1:0]),
        .wr_chan (in_chan),
        .wr_time (in_time),
        .rd_idx  (rd_q),
        .rd_chan (rd_chan),
        .rd_time (rd_time)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_WAIT;
            fill_q  <= '0;
            rd_q    <= '0;
            sel_q   <= '0;
        end else begin
            unique case (state_q)
                ST_WAIT, ST_COLLECT: begin
                    if (open_evt) begin
                        state_q <= ST_COLLECT;
                        fill_q  <= '0;
                        sel_q   <= cfg_ref_chan;
                    end else if (close_evt) begin
                        state_q <= ST_HEAD;
                    end else if (wr_en) begin
                        fill_q <= fill_q + CNT_W'(1);
                    end
                end
                ST_HEAD: begin
                    rd_q    <= '0;
                    state_q <= (fill_q == '0) ? ST_TAIL : ST_BODY;
                end
                ST_BODY: begin
                    if (last_rd) begin
                        state_q <= ST_TAIL;
                    end else begin
                        rd_q <= rd_q + IDX_W'(1);
                    end
                end
                ST_TAIL: state_q <= ST_WAIT;
                default: state_q <= ST_WAIT;
            endcase
        end
    end

    always_comb begin
        out_valid = (state_q == ST_HEAD) || (state_q == ST_BODY) || (state_q == ST_TAIL);
        out_start = (state_q == ST_HEAD);
        out_end   = (state_q == ST_TAIL);
        out_err   = out_valid && !found;
        out_chan  = '0;
        out_time  = '0;
        if (state_q == ST_BODY) begin
            out_chan = rd_chan;
            if (found) begin
                out_time = $signed({1'b0, rd_time}) - $signed({1'b0, ref_time});
            end else begin
                out_time = $signed({1'b0, rd_time});
            end
        end
    end

endmodule

// File: rtl/tdc_ref_sub_chk.sv
module tdc_ref_sub_chk #(
    parameter int DEPTH = 16,
    localparam int BC_W = $clog2(DEPTH + 1) + 1
) (
    input logic clk,
    input logic rst,
    input logic in_ready,
    input logic out_valid,
    input logic out_start,
    input logic out_end,
    input logic out_err
);

    logic [BC_W-1:0] body_cnt;

    always_ff @(posedge clk) begin
        if (rst || out_start) begin
            body_cnt <= '0;
        end else if (out_valid && !out_end && body_cnt < BC_W'(DEPTH + 1)) begin
            body_cnt <= body_cnt + BC_W'(1);
        end
    end

    // R3
    busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    // R2
    head_next_chk: assert property (@(posedge clk) disable iff (rst)
        out_start |=> (out_valid && !out_start));

    // R2
    tail_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        out_end |=> !out_valid);

    // R2
    no_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_end) |=> out_valid);

    // R7
    err_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_start && $past(out_valid)) |-> (out_err == $past(out_err)));

    // R9
    depth_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_start && !out_end) |-> (body_cnt < BC_W'(DEPTH)));

endmodule

bind tdc_ref_sub tdc_ref_sub_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_start (out_start),
    .out_end   (out_end),
    .out_err   (out_err)
);

// File: tb/tdc_ref_sub_bench.sv
module tdc_ref_sub_bench;

    localparam int CHAN_W = 5;
    localparam int TIME_W = 19;
    localparam int DEPTH  = 16;
    localparam int OUT_W  = TIME_W + 1;
    localparam int MAXW   = 48;

    logic                    clk = 1'b0;
    logic                    rst;
    logic [CHAN_W-1:0]       cfg_ref_chan;
    logic                    in_valid, in_start, in_end;
    logic [CHAN_W-1:0]       in_chan;
    logic [TIME_W-1:0]       in_time;
    logic                    in_ready, out_valid, out_start, out_end, out_err;
    logic [CHAN_W-1:0]       out_chan;
    logic signed [OUT_W-1:0] out_time;

    int n_tests = 0;
    int n_fail  = 0;

    tdc_ref_sub #(.CHAN_W(CHAN_W), .TIME_W(TIME_W), .DEPTH(DEPTH)) u_tdc_ref_sub (
        .clk(clk), .rst(rst), .cfg_ref_chan(cfg_ref_chan),
        .in_valid(in_valid), .in_start(in_start), .in_end(in_end),
        .in_chan(in_chan), .in_time(in_time), .in_ready(in_ready),
        .out_valid(out_valid), .out_start(out_start), .out_end(out_end),
        .out_chan(out_chan), .out_time(out_time), .out_err(out_err)
    );

    always #4 clk = ~clk;

    // captured output
    int                      cap_n = 0;
    int                      done_cnt = 0;
    logic                    cap_s [MAXW];
    logic                    cap_e [MAXW];
    logic                    cap_r [MAXW];
    logic [CHAN_W-1:0]       cap_c [MAXW];
    logic signed [OUT_W-1:0] cap_t [MAXW];

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (cap_n < MAXW) begin
                cap_s[cap_n] = out_start;
                cap_e[cap_n] = out_end;
                cap_r[cap_n] = out_err;
                cap_c[cap_n] = out_chan;
                cap_t[cap_n] = out_time;
            end
            cap_n++;
            if (out_end) done_cnt++;
        end
    end

    // event model
    int                raw_n;
    logic [CHAN_W-1:0] raw_c [MAXW];
    logic [TIME_W-1:0] raw_t [MAXW];
    logic [CHAN_W-1:0] ev_ref;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic put(input logic s, input logic e, input logic [CHAN_W-1:0] c,
                       input logic [TIME_W-1:0] t);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_start = s; in_end = e; in_chan = c; in_time = t;
        @(posedge clk);
        #1 in_valid = 1'b0; in_start = 1'b0; in_end = 1'b0;
    endtask

    task automatic ev_open();
        ev_ref = cfg_ref_chan;
        raw_n  = 0;
        put(1'b1, 1'b0, '0, '0);
    endtask

    task automatic ev_hit(input logic [CHAN_W-1:0] c, input logic [TIME_W-1:0] t);
        raw_c[raw_n] = c; raw_t[raw_n] = t; raw_n++;
        put(1'b0, 1'b0, c, t);
    endtask

    task automatic wait_done(input int prev, input string req);
        int k = 0;
        while (done_cnt == prev && k < 200) begin
            @(negedge clk); k++;
        end
        check(done_cnt > prev, req, "event end seen", done_cnt, prev + 1);
    endtask

    // closes the event, waits for replay and checks it against the model
    task automatic ev_close_check(input string req);
        int  prev = done_cnt;
        bit  fnd = 0;
        logic [TIME_W-1:0] rt = '0;
        int  en = 0;
        logic [CHAN_W-1:0]       ec [MAXW];
        logic signed [OUT_W-1:0] et [MAXW];
        cap_n = 0;
        put(1'b0, 1'b1, '0, '0);
        wait_done(prev, req);
        for (int i = 0; i < raw_n; i++)
            if (raw_c[i] == ev_ref && (!fnd || raw_t[i] < rt)) begin
                fnd = 1; rt = raw_t[i];
            end
        for (int i = 0; i < raw_n; i++)
            if (raw_c[i] != ev_ref && en < DEPTH) begin
                ec[en] = raw_c[i];
                et[en] = fnd ? $signed({1'b0, raw_t[i]}) - $signed({1'b0, rt})
                             : $signed({1'b0, raw_t[i]});
                en++;
            end
        check(cap_n == en + 2, req, "word count", cap_n, en + 2);
        if (cap_n == en + 2) begin
            check(cap_s[0] == 1'b1, req, "start marker first", cap_s[0], 1);
            check(cap_e[en + 1] == 1'b1, req, "end marker last", cap_e[en + 1], 1);
            for (int i = 0; i < en; i++) begin
                check(cap_c[i + 1] == ec[i], req, "channel", cap_c[i + 1], ec[i]);
                check(cap_t[i + 1] == et[i], req, "time", cap_t[i + 1], et[i]);
            end
            for (int i = 0; i < en + 2; i++)
                check(cap_r[i] == !fnd, req, "error bit", cap_r[i], !fnd);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; in_start = 1'b0; in_end = 1'b0;
        in_chan = '0; in_time = '0; cfg_ref_chan = 5'd31;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    endtask

    // R2 R4 R5 R8: reference mid-event, positive and negative results
    task automatic t_basic();
        cfg_ref_chan = 5'd31;
        ev_open();
        ev_hit(5'd2, 19'd1500);
        ev_hit(5'd7, 19'd400);
        ev_hit(5'd31, 19'd1000);
        ev_hit(5'd0, 19'd1000);
        ev_hit(5'd12, 19'd524287);
        ev_close_check("R4");
    endtask

    // R3: input held during replay is not taken
    task automatic t_busy();
        int prev = done_cnt;
        cfg_ref_chan = 5'd4;
        ev_open();
        ev_hit(5'd4, 19'd50);
        ev_hit(5'd1, 19'd80);
        ev_hit(5'd2, 19'd90);
        cap_n = 0;
        put(1'b0, 1'b1, '0, '0);
        @(negedge clk);
        check(in_ready == 1'b0, "R3", "in_ready during replay", in_ready, 0);
        in_valid = 1'b1; in_chan = 5'd9; in_time = 19'd7;
        @(negedge clk);
        check(in_ready == 1'b0, "R3", "in_ready during replay", in_ready, 0);
        in_valid = 1'b0;
        wait_done(prev, "R3");
        check(cap_n == 4, "R3", "words in busy event", cap_n, 4);
        check(cap_c[1] == 5'd1 && cap_t[1] == 20'sd30, "R3", "first hit time", cap_t[1], 30);
        check(cap_c[2] == 5'd2 && cap_t[2] == 20'sd40, "R3", "second hit time", cap_t[2], 40);
        @(negedge clk);
        check(in_ready == 1'b1, "R3", "in_ready after end marker", in_ready, 1);
    endtask

    // R6: several reference hits, earliest wins
    task automatic t_multi_ref();
        cfg_ref_chan = 5'd8;
        ev_open();
        ev_hit(5'd8, 19'd700);
        ev_hit(5'd3, 19'd900);
        ev_hit(5'd8, 19'd200);
        ev_hit(5'd8, 19'd650);
        ev_hit(5'd5, 19'd100);
        ev_close_check("R6");
    endtask

    // R7: no reference hit
    task automatic t_no_ref();
        cfg_ref_chan = 5'd20;
        ev_open();
        ev_hit(5'd1, 19'd11);
        ev_hit(5'd19, 19'd300000);
        ev_hit(5'd21, 19'd5);
        ev_close_check("R7");
    endtask

    // R9: overflow, late reference still used
    task automatic t_overflow();
        cfg_ref_chan = 5'd0;
        ev_open();
        for (int i = 0; i < DEPTH + 3; i++)
            ev_hit(5'(i + 1), 19'(1000 + 10 * i));
        ev_hit(5'd0, 19'd1050);
        ev_close_check("R9");
    endtask

    // R10: stray words outside an event
    task automatic t_stray();
        cap_n = 0;
        put(1'b0, 1'b0, 5'd3, 19'd77);
        put(1'b0, 1'b1, '0, '0);
        repeat (6) @(negedge clk);
        check(cap_n == 0, "R10", "output words from stray input", cap_n, 0);
    endtask

    // R11: restart within an event
    task automatic t_restart();
        cfg_ref_chan = 5'd6;
        ev_open();
        ev_hit(5'd6, 19'd10);
        ev_hit(5'd2, 19'd99);
        ev_open();
        ev_hit(5'd3, 19'd500);
        ev_hit(5'd6, 19'd450);
        ev_close_check("R11");
    endtask

    // R12: configuration sampled at the start marker
    task automatic t_cfg();
        cfg_ref_chan = 5'd3;
        ev_open();
        cfg_ref_chan = 5'd7;
        ev_hit(5'd7, 19'd100);
        ev_hit(5'd3, 19'd300);
        ev_hit(5'd9, 19'd250);
        ev_close_check("R12");
        cfg_ref_chan = 5'd31;
    endtask

    // R13: empty event
    task automatic t_empty();
        cfg_ref_chan = 5'd1;
        ev_open();
        ev_close_check("R13");
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_basic();
                t_busy();
                t_multi_ref();
                t_no_ref();
                t_overflow();
                t_stray();
                t_restart();
                t_cfg();
                t_empty();
            end
            begin
                repeat (20000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule